// File: doc/BRIEF.md
# Size-Slot Fetch Queue Consumer

This block drains a single-producer, single-consumer ring of 16-bit size slots. A producer fills a free slot with the length of its next record, counted in 16-byte units. The block watches the slot under its read index. When that slot holds a size, it starts one read from a host-memory read port. The read begins at the block's current host read offset and lands the record in a local command ring. In the same cycle the block clears the slot, which hands the slot back to the producer. No separate write pointer exists.

A downstream parser consumes the landed bytes. The block raises a command-ready flag whenever the parser's command pointer trails the fence, the end of the landed data. Only one read is ever in flight. The block services three things in a fixed priority: first unconsumed data, then the completion of the outstanding read, which moves the fence forward by its length, and only then a new slot.

The host offset wraps to the base of the issue region when a record would run past its end. The landing address likewise wraps to the base of the command ring. After each fetch is handed to the read port, the slot index and the host offset are published on output registers.

Top module: `fetchq_consumer`

## Requirements
- R1: After synchronous reset, slot_idx, cmd_ptr, cmd_fence, pub_rd_idx and pub_host_off are 0, and rd_req_valid, slot_clr and cmd_ready are low.
- R2: Bits 14:0 of a slot are its size in 16-byte units. Bit 15 is a stall flag that is masked from the size, so a slot value v requests rd_req_len = (v & 0x7FFF) * 16 bytes.
- R3: A launch happens when there is no unconsumed data, no read is outstanding and the size field is nonzero. In that cycle slot_clr is high for the slot at slot_idx. From the next cycle rd_req_valid is high, and rd_req_valid, rd_req_src, rd_req_dst and rd_req_len hold steady until rd_req_ready is sampled high.
- R4: cmd_ready is high exactly when cmd_ptr differs from cmd_fence. While it is high, no slot is cleared and no read completion is absorbed.
- R5: At most one read is outstanding. A read is outstanding from its launch until its completion is absorbed, and no slot is cleared during that time.
- R6: rd_done counts only when the request has already been accepted and is outstanding. Otherwise it is ignored. Once counted, and with no unconsumed data, cmd_fence advances by the read length in the following cycle and the read stops being outstanding.
- R7: slot_idx advances by one, modulo NUM_SLOTS, each time a slot is cleared.
- R8: rd_req_src is the host offset, or 0 when offset + length exceeds ISSUE_BYTES. The host offset then becomes rd_req_src + length.
- R9: rd_req_dst is cmd_fence, or 0 when cmd_fence + length exceeds RING_BYTES. In the wrapping case, cmd_ptr and cmd_fence both become 0 at the launch.
- R10: A slot whose value is exactly 0x8000 (stall flag set, size zero) is cleared and the index advances, but no read is started.
- R11: The cycle after a request is accepted, pub_rd_idx takes the advanced slot index and pub_host_off takes the advanced host offset. The cycle after a 0x8000 slot is dropped, pub_rd_idx takes the advanced index.
- R12: When consume is high and cmd_ready is high, cmd_ptr advances by consume_len. When cmd_ready is low, consume has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_idx | output | IDX_W | Index of the slot being watched |
| slot_data | input | 16 | Contents of the slot at slot_idx |
| slot_clr | output | 1 | Write zero to the slot at slot_idx this cycle |
| rd_req_valid | output | 1 | Host read request pending |
| rd_req_ready | input | 1 | Read port accepts the request |
| rd_req_src | output | HOFF_W | Host byte offset to read from |
| rd_req_dst | output | RING_W | Local ring byte address to land at |
| rd_req_len | output | 19 | Read length in bytes |
| rd_done | input | 1 | Accepted read has completed (pulse) |
| cmd_ready | output | 1 | Unconsumed command bytes exist |
| cmd_ptr | output | RING_W | Parser's command pointer |
| cmd_fence | output | RING_W | End of landed data |
| consume | input | 1 | Parser consumes bytes this cycle |
| consume_len | input | 19 | Number of bytes consumed |
| pub_rd_idx | output | IDX_W | Published slot read index |
| pub_host_off | output | HOFF_W | Published host read offset |

## Verification
Two functions can fall in the same cycle: the host-offset wrap and the landing-address wrap. Both trigger inside one launch when a record fits neither the rest of the issue region nor the rest of the command ring. The record sequence is chosen so that a 1024-byte record arrives with the host offset at 2048 and the fence at 1024, so src and dst must both come out as 0 and the command pointer and fence must both reset in that one launch. The behavioural model checks src, dst, fence and pointer on every clock, and a separate check confirms that this double-wrap launch occurred.

// File: rtl/fq_pkg.sv
package fq_pkg;

    localparam int SLOT_W     = 16;
    localparam int SIZE_W     = 15;
    localparam int UNIT_SHIFT = 4;
    localparam int LEN_W      = SIZE_W + UNIT_SHIFT;

    typedef struct packed {
        logic              hold;
        logic [SIZE_W-1:0] units;
    } slot_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_DRAIN,
        ACT_WAIT,
        ACT_ABSORB,
        ACT_LAUNCH,
        ACT_SKIP
    } act_t;

    function automatic logic [LEN_W-1:0] slot_bytes(slot_t s);
        return {s.units, {UNIT_SHIFT{1'b0}}};
    endfunction

    function automatic logic fits(logic [31:0] start, logic [31:0] len, logic [31:0] limit);
        return (start + len) <= limit;
    endfunction

    function automatic act_t pick_action(logic has_data, logic pending, logic seen, slot_t s);
        if (has_data)
            return ACT_DRAIN;
        else if (pending)
            return seen ? ACT_ABSORB : ACT_WAIT;
        else if (s.units != '0)
            return ACT_LAUNCH;
        else if (s.hold)
            return ACT_SKIP;
        else
            return ACT_IDLE;
    endfunction

endpackage

// File: rtl/fq_slot_walker.sv
module fq_slot_walker #(
    parameter  int NUM_SLOTS = 1534,
    localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] idx_next
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

    always_comb begin
        if (idx == LAST)
            idx_next = '0;
        else
            idx_next = idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (take)
            idx <= idx_next;
    end

endmodule

// File: rtl/fq_host_cursor.sv
module fq_host_cursor
    import fq_pkg::*;
#(
    parameter  int ISSUE_BYTES = 64 * 1024 * 1024,
    localparam int HOFF_W      = $clog2(ISSUE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [LEN_W-1:0]  len,
    output logic [HOFF_W-1:0] src,
    output logic [HOFF_W-1:0] off
);

    logic room;

    always_comb begin
        room = fits(32'(off), 32'(len), 32'(ISSUE_BYTES));
        src  = room ? off : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            off <= '0;
        else if (advance)
            off <= src + HOFF_W'(len);
    end

endmodule

// File: rtl/fq_land_window.sv
module fq_land_window
    import fq_pkg::*;
#(
    parameter  int RING_BYTES = 256 * 1024,
    localparam int RING_W     = $clog2(RING_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [LEN_W-1:0]  launch_len,
    input  logic              absorb,
    input  logic [LEN_W-1:0]  absorb_len,
    input  logic              consume,
    input  logic [LEN_W-1:0]  consume_len,
    output logic [RING_W-1:0] cmd_ptr,
    output logic [RING_W-1:0] fence,
    output logic [RING_W-1:0] land_dst,
    output logic              has_data
);

    logic wrap_land;

    always_comb begin
        wrap_land = !fits(32'(fence), 32'(launch_len), 32'(RING_BYTES));
        land_dst  = wrap_land ? '0 : fence;
        has_data  = (cmd_ptr != fence);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_ptr <= '0;
            fence   <= '0;
        end else if (launch && wrap_land) begin
            cmd_ptr <= '0;
            fence   <= '0;
        end else if (absorb) begin
            fence <= fence + RING_W'(absorb_len);
        end else if (consume && has_data) begin
            cmd_ptr <= cmd_ptr + RING_W'(consume_len);
        end
    end

endmodule

// File: rtl/fq_read_track.sv
module fq_read_track
    import fq_pkg::*;
#(
    parameter int HOFF_W = 27,
    parameter int RING_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [HOFF_W-1:0] launch_src,
    input  logic [RING_W-1:0] launch_dst,
    input  logic [LEN_W-1:0]  launch_len,
    input  logic              absorb,
    input  logic              req_ready,
    input  logic              done,
    output logic              req_valid,
    output logic [HOFF_W-1:0] req_src,
    output logic [RING_W-1:0] req_dst,
    output logic [LEN_W-1:0]  req_len,
    output logic              pending,
    output logic              seen,
    output logic              accepted
);

    assign accepted = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_src   <= '0;
            req_dst   <= '0;
            req_len   <= '0;
            pending   <= 1'b0;
            seen      <= 1'b0;
        end else begin
            if (launch) begin
                req_valid <= 1'b1;
                req_src   <= launch_src;
                req_dst   <= launch_dst;
                req_len   <= launch_len;
                pending   <= 1'b1;
            end else if (accepted) begin
                req_valid <= 1'b0;
            end

            if (absorb) begin
                pending <= 1'b0;
                seen    <= 1'b0;
            end else if (done && pending && !req_valid) begin
                seen <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fetchq_consumer.sv
module fetchq_consumer
    import fq_pkg::*;
#(
    parameter  int NUM_SLOTS   = 1534,
    parameter  int ISSUE_BYTES = 64 * 1024 * 1024,
    parameter  int RING_BYTES  = 256 * 1024,
    localparam int IDX_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int HOFF_W      = $clog2(ISSUE_BYTES + 1),
    localparam int RING_W      = $clog2(RING_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [IDX_W-1:0]  slot_idx,
    input  logic [SLOT_W-1:0] slot_data,
    output logic              slot_clr,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [HOFF_W-1:0] rd_req_src,
    output logic [RING_W-1:0] rd_req_dst,
    output logic [LEN_W-1:0]  rd_req_len,
    input  logic              rd_done,
    output logic              cmd_ready,
    output logic [RING_W-1:0] cmd_ptr,
    output logic [RING_W-1:0] cmd_fence,
    input  logic              consume,
    input  logic [LEN_W-1:0]  consume_len,
    output logic [IDX_W-1:0]  pub_rd_idx,
    output logic [HOFF_W-1:0] pub_host_off
);

    slot_t             slot_q;
    act_t              act;
    logic              has_data;
    logic              pending;
    logic              seen;
    logic              accepted;
    logic              launch;
    logic              skip;
    logic              absorb;
    logic              take;
    logic [LEN_W-1:0]  slot_len;
    logic [IDX_W-1:0]  idx_next;
    logic [HOFF_W-1:0] host_src;
    logic [HOFF_W-1:0] host_off;
    logic [RING_W-1:0] land_dst;

    always_comb begin
        slot_q   = slot_t'(slot_data);
        slot_len = slot_bytes(slot_q);
        act      = pick_action(has_data, pending, seen, slot_q);
        launch   = (act == ACT_LAUNCH);
        skip     = (act == ACT_SKIP);
        absorb   = (act == ACT_ABSORB);
        take     = launch || skip;
    end

    assign slot_clr  = take;
    assign cmd_ready = has_data;

    fq_slot_walker #(.NUM_SLOTS(NUM_SLOTS)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .idx      (slot_idx),
        .idx_next (idx_next)
    );

    fq_host_cursor #(.ISSUE_BYTES(ISSUE_BYTES)) u_host (
        .clk     (clk),
        .rst     (rst),
        .advance (launch),
        .len     (slot_len),
        .src     (host_src),
        .off     (host_off)
    );

    fq_land_window #(.RING_BYTES(RING_BYTES)) u_win (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_len  (slot_len),
        .absorb      (absorb),
        .absorb_len  (rd_req_len),
        .consume     (consume),
        .consume_len (consume_len),
        .cmd_ptr     (cmd_ptr),
        .fence       (cmd_fence),
        .land_dst    (land_dst),
        .has_data    (has_data)
    );

    fq_read_track #(.HOFF_W(HOFF_W), .RING_W(RING_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_src (host_src),
        .launch_dst (land_dst),
        .launch_len (slot_len),
        .absorb     (absorb),
        .req_ready  (rd_req_ready),
        .done       (rd_done),
        .req_valid  (rd_req_valid),
        .req_src    (rd_req_src),
        .req_dst    (rd_req_dst),
        .req_len    (rd_req_len),
        .pending    (pending),
        .seen       (seen),
        .accepted   (accepted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pub_rd_idx   <= '0;
            pub_host_off <= '0;
        end else if (accepted) begin
            pub_rd_idx   <= slot_idx;
            pub_host_off <= host_off;
        end else if (skip) begin
            pub_rd_idx <= idx_next;
        end
    end

endmodule

// File: rtl/fq_consumer_chk.sv
module fq_consumer_chk #(
    parameter  int NUM_SLOTS   = 1534,
    parameter  int ISSUE_BYTES = 64 * 1024 * 1024,
    parameter  int RING_BYTES  = 256 * 1024,
    localparam int IDX_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int HOFF_W      = $clog2(ISSUE_BYTES + 1),
    localparam int RING_W      = $clog2(RING_BYTES + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [IDX_W-1:0]  slot_idx,
    input logic [15:0]       slot_data,
    input logic              slot_clr,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [HOFF_W-1:0] rd_req_src,
    input logic [RING_W-1:0] rd_req_dst,
    input logic [18:0]       rd_req_len,
    input logic              cmd_ready,
    input logic [RING_W-1:0] cmd_ptr,
    input logic [RING_W-1:0] cmd_fence
);

    assert_clr_needs_slot_R3: assert property (@(posedge clk) disable iff (rst)
        slot_clr |-> (slot_data != 16'h0));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !rd_req_ready) |=>
            (rd_req_valid && $stable(rd_req_src) && $stable(rd_req_dst) && $stable(rd_req_len)));

    assert_len_units_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> ((rd_req_len[3:0] == 4'h0) && (rd_req_len != '0)));

    assert_no_clr_busy_R4: assert property (@(posedge clk) disable iff (rst)
        slot_clr |-> !cmd_ready);

    assert_single_read_R5: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> !slot_clr);

    assert_idx_step_R7: assert property (@(posedge clk) disable iff (rst)
        slot_clr |=> (int'(slot_idx) == ((int'($past(slot_idx)) + 1) % NUM_SLOTS)));

    assert_host_fit_R8: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> ((32'(rd_req_src) + 32'(rd_req_len)) <= 32'(ISSUE_BYTES)));

    assert_ring_fit_R9: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> ((32'(rd_req_dst) + 32'(rd_req_len)) <= 32'(RING_BYTES)));

    assert_ptr_order_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_ptr <= cmd_fence);

endmodule

bind fetchq_consumer fq_consumer_chk #(
    .NUM_SLOTS   (NUM_SLOTS),
    .ISSUE_BYTES (ISSUE_BYTES),
    .RING_BYTES  (RING_BYTES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .slot_idx     (slot_idx),
    .slot_data    (slot_data),
    .slot_clr     (slot_clr),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_src   (rd_req_src),
    .rd_req_dst   (rd_req_dst),
    .rd_req_len   (rd_req_len),
    .cmd_ready    (cmd_ready),
    .cmd_ptr      (cmd_ptr),
    .cmd_fence    (cmd_fence)
);

// File: tb/fetchq_consumer_test.sv
module fetchq_consumer_test;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 5;
    localparam int IB         = 2048;
    localparam int RB         = 1024;
    localparam int IDX_W      = 3;
    localparam int HOFF_W     = 12;
    localparam int RING_W     = 11;
    localparam int LEN_W      = 19;
    localparam int NREC       = 48;
    localparam int WATCHDOG   = 50000;

    logic              clk;
    logic              rst;
    logic [IDX_W-1:0]  slot_idx;
    logic [15:0]       slot_data;
    logic              slot_clr;
    logic              rd_req_valid;
    logic              rd_req_ready;
    logic [HOFF_W-1:0] rd_req_src;
    logic [RING_W-1:0] rd_req_dst;
    logic [LEN_W-1:0]  rd_req_len;
    logic              rd_done;
    logic              cmd_ready;
    logic [RING_W-1:0] cmd_ptr;
    logic [RING_W-1:0] cmd_fence;
    logic              consume;
    logic [LEN_W-1:0]  consume_len;
    logic [IDX_W-1:0]  pub_rd_idx;
    logic [HOFF_W-1:0] pub_host_off;

    fetchq_consumer #(.NUM_SLOTS(NS), .ISSUE_BYTES(IB), .RING_BYTES(RB)) uut (
        .clk(clk), .rst(rst), .slot_idx(slot_idx), .slot_data(slot_data), .slot_clr(slot_clr),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_src(rd_req_src),
        .rd_req_dst(rd_req_dst), .rd_req_len(rd_req_len), .rd_done(rd_done),
        .cmd_ready(cmd_ready), .cmd_ptr(cmd_ptr), .cmd_fence(cmd_fence),
        .consume(consume), .consume_len(consume_len),
        .pub_rd_idx(pub_rd_idx), .pub_host_off(pub_host_off)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // slot ring storage, written only at the clock edge
    logic [15:0] mem [NS];
    logic        p_we;
    int          p_widx;
    logic [15:0] p_val;
    assign slot_data = mem[slot_idx];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NS; i++) mem[i] <= 16'h0;
        end else begin
            if (slot_clr) mem[slot_idx] <= 16'h0;
            if (p_we) mem[p_widx] <= p_val;
        end
    end

    function automatic logic [15:0] rec_size(int i);
        case (i % 16)
            0: return 16'd4;     1: return 16'd8;     2: return 16'd20;    3: return 16'd32;
            4: return 16'h8000;  5: return 16'h8004;  6: return 16'd48;    7: return 16'd12;
            8: return 16'd64;    9: return 16'd4;     10: return 16'h8000; 11: return 16'd16;
            12: return 16'd40;   13: return 16'd8;    14: return 16'd28;   default: return 16'd4;
        endcase
    endfunction

    // behavioural reference model
    int m_idx, m_host, m_cmd, m_fence, m_plen, m_src, m_dst, m_len, m_pub_idx, m_pub_host;
    bit m_pend, m_seen, m_reqv;
    bit hit_host_wrap, hit_ring_wrap, hit_both, hit_skip, hit_idx_wrap, hit_mask;
    bit hit_ign_consume, hit_ign_done, hit_backpressure;

    always @(posedge clk) begin
        if (rst) begin
            m_idx = 0; m_host = 0; m_cmd = 0; m_fence = 0; m_plen = 0;
            m_src = 0; m_dst = 0; m_len = 0; m_pub_idx = 0; m_pub_host = 0;
            m_pend = 0; m_seen = 0; m_reqv = 0;
        end else begin
            int s, units, len, nh, nr;
            bit old_reqv, old_pend, old_seen;
            s = int'(mem[m_idx]);
            units = s & 32'h7FFF;
            old_reqv = m_reqv; old_pend = m_pend; old_seen = m_seen;
            if (rd_done && old_pend && !old_reqv) m_seen = 1;
            if (rd_done && !old_pend) hit_ign_done = 1;
            if (old_reqv && !rd_req_ready) hit_backpressure = 1;
            if (old_reqv && rd_req_ready) begin
                m_reqv = 0; m_pub_idx = m_idx; m_pub_host = m_host;
            end
            if (m_cmd != m_fence) begin
                if (consume) m_cmd = m_cmd + int'(consume_len);
            end else begin
                if (consume) hit_ign_consume = 1;
                if (old_pend) begin
                    if (old_seen) begin
                        m_fence = m_fence + m_plen; m_pend = 0; m_seen = 0;
                    end
                end else if (units != 0) begin
                    len = units * 16;
                    if (s >= 32'h8000) hit_mask = 1;
                    nr = 0; nh = 0;
                    if (m_fence + len > RB) begin m_dst = 0; m_cmd = 0; nr = 1; end
                    else m_dst = m_fence;
                    if (m_host + len > IB) begin m_src = 0; nh = 1; end
                    else m_src = m_host;
                    if (nr) hit_ring_wrap = 1;
                    if (nh) hit_host_wrap = 1;
                    if (nr && nh) hit_both = 1;
                    m_fence = m_dst; m_host = m_src + len; m_len = len; m_plen = len;
                    m_reqv = 1; m_pend = 1;
                    if (m_idx == NS - 1) hit_idx_wrap = 1;
                    m_idx = (m_idx + 1) % NS;
                end else if (s == 32'h8000) begin
                    hit_skip = 1;
                    if (m_idx == NS - 1) hit_idx_wrap = 1;
                    m_idx = (m_idx + 1) % NS;
                    m_pub_idx = m_idx;
                end
            end
        end
    end

    int n_chk, n_fail;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_cycle();
        bit exp_clr;
        exp_clr = (m_cmd == m_fence) && !m_pend && (mem[m_idx] != 16'h0);
        chk(int'(slot_idx) == m_idx, "R7 slot index", slot_idx, m_idx);
        chk(slot_clr == exp_clr, "R3 R10 slot clear", slot_clr, exp_clr);
        chk(rd_req_valid == m_reqv, "R5 request valid", rd_req_valid, m_reqv);
        if (m_reqv) begin
            chk(int'(rd_req_src) == m_src, "R8 request source", rd_req_src, m_src);
            chk(int'(rd_req_dst) == m_dst, "R9 request destination", rd_req_dst, m_dst);
            chk(int'(rd_req_len) == m_len, "R2 request length", rd_req_len, m_len);
        end
        chk(cmd_ready == (m_cmd != m_fence), "R4 command ready", cmd_ready, m_cmd != m_fence);
        chk(int'(cmd_ptr) == m_cmd, "R12 command pointer", cmd_ptr, m_cmd);
        chk(int'(cmd_fence) == m_fence, "R6 fence", cmd_fence, m_fence);
        chk(int'(pub_rd_idx) == m_pub_idx, "R11 published index", pub_rd_idx, m_pub_idx);
        chk(int'(pub_host_off) == m_pub_host, "R11 published offset", pub_host_off, m_pub_host);
    endtask

    int  cyc, rec_i, wptr, dly, idle_cnt, eaten, exp_bytes;
    bit  outstanding, acc_flag, timed_out, all_free;

    initial begin
        n_chk = 0; n_fail = 0; cyc = 0; rec_i = 0; wptr = 0; dly = 0; idle_cnt = 0;
        eaten = 0; outstanding = 0; acc_flag = 0; timed_out = 0;
        rst = 1'b1; rd_req_ready = 1'b0; rd_done = 1'b0; consume = 1'b0; consume_len = '0;
        p_we = 1'b0; p_widx = 0; p_val = 16'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_req_valid == 1'b0, "R1 reset request valid", rd_req_valid, 0);
        chk(slot_clr == 1'b0, "R1 reset slot clear", slot_clr, 0);
        chk(cmd_ready == 1'b0, "R1 reset ready", cmd_ready, 0);
        chk(cmd_ptr == '0 && cmd_fence == '0, "R1 reset pointers", cmd_fence, 0);
        chk(slot_idx == '0 && pub_rd_idx == '0 && pub_host_off == '0, "R1 reset indices", pub_host_off, 0);
        rst = 1'b0;

        exp_bytes = 0;
        for (int i = 0; i < NREC; i++) exp_bytes += int'(rec_size(i) & 16'h7FFF) * 16;

        while (idle_cnt < 10 && !timed_out) begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) timed_out = 1;
            compare_cycle();

            // host read port
            if (acc_flag) begin outstanding = 1; dly = 2 + (cyc % 4); end
            rd_done = 1'b0;
            if (outstanding) begin
                if (dly == 0) begin rd_done = 1'b1; outstanding = 0; end
                else dly--;
            end else if (!rd_req_valid && (cyc % 11 == 0)) begin
                rd_done = 1'b1;
            end
            rd_req_ready = (cyc % 3) != 0;
            acc_flag = rd_req_valid && rd_req_ready;

            // parser
            consume = 1'b0; consume_len = '0;
            if (cmd_ready && (cyc % 5 != 0)) begin
                int avail, ch;
                avail = int'(cmd_fence) - int'(cmd_ptr);
                ch = 16 * (1 + cyc % 4);
                if (ch > avail) ch = avail;
                consume = 1'b1; consume_len = LEN_W'(ch); eaten += ch;
            end else if (!cmd_ready && (cyc % 7 == 0)) begin
                consume = 1'b1; consume_len = LEN_W'(16);
            end

            // producer
            p_we = 1'b0;
            if (rec_i < NREC && mem[wptr] == 16'h0 && (cyc % 2 == 0)) begin
                p_we = 1'b1; p_widx = wptr; p_val = rec_size(rec_i);
                rec_i++; wptr = (wptr + 1) % NS;
            end

            all_free = 1;
            for (int i = 0; i < NS; i++) if (mem[i] != 16'h0) all_free = 0;
            if (rec_i == NREC && all_free && !p_we && !rd_req_valid && !cmd_ready && !m_pend)
                idle_cnt++;
            else
                idle_cnt = 0;
        end

        if (timed_out) chk(1'b0, "watchdog R5", cyc, WATCHDOG);
        chk(eaten == exp_bytes, "R12 total bytes consumed", eaten, exp_bytes);
        chk(hit_host_wrap, "R8 host wrap seen", hit_host_wrap, 1);
        chk(hit_ring_wrap, "R9 ring wrap seen", hit_ring_wrap, 1);
        chk(hit_both, "R9 R8 double wrap seen", hit_both, 1);
        chk(hit_skip, "R10 flag-only slot seen", hit_skip, 1);
        chk(hit_idx_wrap, "R7 index wrap seen", hit_idx_wrap, 1);
        chk(hit_mask, "R2 masked flag seen", hit_mask, 1);
        chk(hit_ign_consume, "R12 ignored consume seen", hit_ign_consume, 1);
        chk(hit_ign_done, "R6 ignored done seen", hit_ign_done, 1);
        chk(hit_backpressure, "R3 request held seen", hit_backpressure, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule